// File: doc/BRIEF.md
# Single-Cell Battery Protection Controller

This block is the digital decision core of a one-cell lithium battery protector. It takes comparator flags that have already been digitised and synchronised: the cell voltage against five thresholds, the current-sense level against three fault levels and their release levels, and charger-present and load-present indications. From these it drives the enables of the charge and discharge switches, a pull-up and a pull-down on the sense node, and a standby output that removes internal bias.

Every fault detection and every fault release is qualified by its own timer, which counts a slow timebase tick. A condition that drops before its timer expires leaves no trace. The modes nest:
- A short-circuit check runs inside overcharge mode.
- Overdischarge drops into standby, which can wake either on a charger or on a higher wake-up voltage.
- While the cell is overdischarged, charge overcurrent is not watched.

Top module: `batt_guard_ctrl`

## Requirements
- R1: After reset the block is in normal mode: charge and discharge enables high, sense pull-up, sense pull-down and standby low. All outputs are active high.
- R2: A detection or release condition takes effect only when it has held on every clock edge while its timer counted the configured number of ticks. If the condition drops earlier, the timer clears, and a shorter pulse changes no output.
- R3: A cell at or above the overcharge level for the overcharge delay clears the charge enable. The enable returns only when the charger is absent and the cell has been below the overcharge-release level for the overcharge-release delay.
- R4: In overcharge mode, a short-circuit level held for the short-circuit delay also clears the discharge enable and raises the pull-down. When the load is gone and the short-circuit flag is low, the block returns to overcharge mode, not to normal mode.
- R5: A cell below the overdischarge level for the overdischarge delay clears the discharge enable, raises the pull-up and raises standby. The charge enable stays high. The pull-up and pull-down are never high together.
- R6: Standby is left on the next clock edge in one of two ways. If a charger is present, the block moves to a charging state with both enables high and no pull-up. If no charger is present and the wake-up flag is high, the block returns to normal mode.
- R7: In the charging state, the block returns to normal once the overdischarge-release flag has held for its delay. If the charger goes away before that, the block falls back to standby.
- R8: Charge overcurrent is ignored while the cell is overdischarged, in standby and in the charging state.
- R9: A discharge overcurrent held for its delay clears the discharge enable and raises the pull-down. Recovery needs the load absent and the release flag held for the discharge release delay.
- R10: A short-circuit level held for its much shorter delay in normal mode gives the same outputs as R9 and recovers the same way.
- R11: A charge overcurrent held for its delay clears the charge enable. Recovery needs the charger absent and the charge release flag held for its delay.
- R12: When several detections qualify on the same edge in normal mode, the priority is short circuit, then discharge overcurrent, then overdischarge, then overcharge, then charge overcurrent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| cell_ovc_i | input | 1 | Cell at or above the overcharge level |
| cell_ovc_rel_i | input | 1 | Cell below the overcharge-release level |
| cell_udc_i | input | 1 | Cell below the overdischarge level |
| cell_udc_rel_i | input | 1 | Cell above the overdischarge-release level |
| cell_wake_i | input | 1 | Cell above the wake-up level |
| sns_doc_i | input | 1 | Sense at or above the discharge overcurrent level |
| sns_doc_rel_i | input | 1 | Sense at or below the discharge release level |
| sns_short_i | input | 1 | Sense at or above the short-circuit level |
| sns_coc_i | input | 1 | Sense at or below the charge overcurrent level |
| sns_coc_rel_i | input | 1 | Sense at or above the charge release level |
| charger_i | input | 1 | Charger present |
| load_i | input | 1 | Load present |
| chg_en_o | output | 1 | Charge switch enable |
| dchg_en_o | output | 1 | Discharge switch enable |
| sns_pullup_o | output | 1 | Sense node pull-up enable |
| sns_pulldown_o | output | 1 | Sense node pull-down enable |
| standby_o | output | 1 | Standby, internal bias off |

## Verification
The assertions assume that every input flag is synchronous to the clock and settles before the rising edge. They also assume that physically exclusive flags are never high together; for example, overcharge and overdischarge never coincide. The stimulus changes inputs only on the falling edge and drives the tick from its own falling-edge process. Each scenario clears flags that contradict the next one before that scenario starts, so mode changes come only from the intended condition.

// File: rtl/batt_guard_pkg.sv
package batt_guard_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_OVC,
    ST_OVC_SC,
    ST_UDC_STBY,
    ST_UDC_CHG,
    ST_DOC,
    ST_COC
  } guard_state_e;

  localparam int unsigned TM_OVC_DET = 0;
  localparam int unsigned TM_OVC_REL = 1;
  localparam int unsigned TM_UDC_DET = 2;
  localparam int unsigned TM_UDC_REL = 3;
  localparam int unsigned TM_DOC_DET = 4;
  localparam int unsigned TM_DOC_REL = 5;
  localparam int unsigned TM_SC_DET  = 6;
  localparam int unsigned TM_COC_DET = 7;
  localparam int unsigned TM_COC_REL = 8;
  localparam int unsigned N_TMR      = 9;

endpackage

// File: rtl/batt_guard_qtimer.sv
module batt_guard_qtimer #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cond_i,
  output logic done_o
);

  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!cond_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = cond_i && (cnt_q == LIMIT);

  AST_QUAL_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cond_i)); // R2

endmodule

// File: rtl/batt_guard_fsm.sv
module batt_guard_fsm
  import batt_guard_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_TMR-1:0] done_i,
  input  logic             charger_i,
  input  logic             load_i,
  input  logic             sns_short_i,
  input  logic             cell_wake_i,
  output guard_state_e     state_o
);

  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if      (done_i[TM_SC_DET])  state_d = ST_DOC;
        else if (done_i[TM_DOC_DET]) state_d = ST_DOC;
        else if (done_i[TM_UDC_DET]) state_d = ST_UDC_STBY;
        else if (done_i[TM_OVC_DET]) state_d = ST_OVC;
        else if (done_i[TM_COC_DET]) state_d = ST_COC;
      end
      ST_OVC: begin
        if      (done_i[TM_SC_DET])  state_d = ST_OVC_SC;
        else if (done_i[TM_OVC_REL]) state_d = ST_NORMAL;
      end
      ST_OVC_SC:   if (!load_i && !sns_short_i) state_d = ST_OVC;
      ST_UDC_STBY: begin
        if      (charger_i)   state_d = ST_UDC_CHG;
        else if (cell_wake_i) state_d = ST_NORMAL;
      end
      ST_UDC_CHG: begin
        if      (done_i[TM_UDC_REL]) state_d = ST_NORMAL;
        else if (!charger_i)         state_d = ST_UDC_STBY;
      end
      ST_DOC:  if (done_i[TM_DOC_REL]) state_d = ST_NORMAL;
      ST_COC:  if (done_i[TM_COC_REL]) state_d = ST_NORMAL;
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NORMAL;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_OVC_EXIT_NO_CHARGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == ST_OVC) && state_q == ST_NORMAL) |-> $past(!charger_i)); // R3
  AST_SC_BACK_TO_OVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OVC_SC && !load_i && !sns_short_i) |=> state_q == ST_OVC); // R4
  AST_STBY_CHARGER_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UDC_STBY && charger_i) |=> state_q == ST_UDC_CHG); // R6
  AST_NO_COC_FROM_UDC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_UDC_STBY || state_q == ST_UDC_CHG) |=> state_q != ST_COC); // R8
  AST_DOC_EXIT_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q == ST_DOC) && state_q == ST_NORMAL) |-> $past(!load_i)); // R9

endmodule

// File: rtl/batt_guard_outdec.sv
module batt_guard_outdec
  import batt_guard_pkg::*;
(
  input  guard_state_e state_i,
  output logic         chg_en_o,
  output logic         dchg_en_o,
  output logic         pullup_o,
  output logic         pulldown_o,
  output logic         standby_o
);

  always_comb begin
    chg_en_o   = 1'b1;
    dchg_en_o  = 1'b1;
    pullup_o   = 1'b0;
    pulldown_o = 1'b0;
    standby_o  = 1'b0;
    unique case (state_i)
      ST_OVC, ST_COC: chg_en_o = 1'b0;
      ST_OVC_SC: begin
        chg_en_o   = 1'b0;
        dchg_en_o  = 1'b0;
        pulldown_o = 1'b1;
      end
      ST_UDC_STBY: begin
        dchg_en_o = 1'b0;
        pullup_o  = 1'b1;
        standby_o = 1'b1;
      end
      ST_DOC: begin
        dchg_en_o  = 1'b0;
        pulldown_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/batt_guard_ctrl.sv
module batt_guard_ctrl
  import batt_guard_pkg::*;
#(
  parameter int unsigned OVC_DET_TICKS = 10000,
  parameter int unsigned OVC_REL_TICKS = 160,
  parameter int unsigned UDC_DET_TICKS = 200,
  parameter int unsigned UDC_REL_TICKS = 11,
  parameter int unsigned DOC_DET_TICKS = 120,
  parameter int unsigned DOC_REL_TICKS = 40,
  parameter int unsigned SC_DET_TICKS  = 4,
  parameter int unsigned COC_DET_TICKS = 160,
  parameter int unsigned COC_REL_TICKS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cell_ovc_i,
  input  logic cell_ovc_rel_i,
  input  logic cell_udc_i,
  input  logic cell_udc_rel_i,
  input  logic cell_wake_i,
  input  logic sns_doc_i,
  input  logic sns_doc_rel_i,
  input  logic sns_short_i,
  input  logic sns_coc_i,
  input  logic sns_coc_rel_i,
  input  logic charger_i,
  input  logic load_i,
  output logic chg_en_o,
  output logic dchg_en_o,
  output logic sns_pullup_o,
  output logic sns_pulldown_o,
  output logic standby_o
);

  localparam int unsigned DLY [N_TMR] = '{
    OVC_DET_TICKS, OVC_REL_TICKS, UDC_DET_TICKS, UDC_REL_TICKS,
    DOC_DET_TICKS, DOC_REL_TICKS, SC_DET_TICKS, COC_DET_TICKS, COC_REL_TICKS
  };

  guard_state_e     state;
  logic [N_TMR-1:0] cond, done;

  // each timer is gated by the mode it qualifies in, so leaving the mode clears it
  always_comb begin
    cond             = '0;
    cond[TM_OVC_DET] = (state == ST_NORMAL) && cell_ovc_i;
    cond[TM_OVC_REL] = (state == ST_OVC) && !charger_i && cell_ovc_rel_i;
    cond[TM_UDC_DET] = (state == ST_NORMAL) && cell_udc_i;
    cond[TM_UDC_REL] = (state == ST_UDC_CHG) && cell_udc_rel_i;
    cond[TM_DOC_DET] = (state == ST_NORMAL) && sns_doc_i;
    cond[TM_DOC_REL] = (state == ST_DOC) && !load_i && sns_doc_rel_i;
    cond[TM_SC_DET]  = ((state == ST_NORMAL) || (state == ST_OVC)) && sns_short_i;
    cond[TM_COC_DET] = (state == ST_NORMAL) && sns_coc_i;
    cond[TM_COC_REL] = (state == ST_COC) && !charger_i && sns_coc_rel_i;
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    batt_guard_qtimer #(.DELAY(DLY[g])) i_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .cond_i (cond[g]),
      .done_o (done[g])
    );
  end

  batt_guard_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .charger_i   (charger_i),
    .load_i      (load_i),
    .sns_short_i (sns_short_i),
    .cell_wake_i (cell_wake_i),
    .state_o     (state)
  );

  batt_guard_outdec i_dec (
    .state_i    (state),
    .chg_en_o   (chg_en_o),
    .dchg_en_o  (dchg_en_o),
    .pullup_o   (sns_pullup_o),
    .pulldown_o (sns_pulldown_o),
    .standby_o  (standby_o)
  );

  AST_PULL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sns_pullup_o && sns_pulldown_o)); // R5
  AST_STBY_DCHG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (!dchg_en_o && chg_en_o)); // R5
  AST_STBY_LEAVES_CHG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && charger_i) |=> (!standby_o && dchg_en_o)); // R6

endmodule

// File: tb/test_batt_guard_ctrl.sv
module test_batt_guard_ctrl;

  localparam int D_OVC = 6, D_OVR = 3, D_UDC = 5, D_UDR = 2, D_DOC = 5,
                 D_DOCR = 3, D_SC = 2, D_COC = 5, D_COCR = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic c_ovc = 0, c_ovr = 0, c_udc = 0, c_udr = 0, c_wake = 0;
  logic s_doc = 0, s_docr = 0, s_sc = 0, s_coc = 0, s_cocr = 0;
  logic chgr = 0, load = 0;
  logic chg_en, dchg_en, pu, pd, sb;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  batt_guard_ctrl #(
    .OVC_DET_TICKS(D_OVC), .OVC_REL_TICKS(D_OVR), .UDC_DET_TICKS(D_UDC),
    .UDC_REL_TICKS(D_UDR), .DOC_DET_TICKS(D_DOC), .DOC_REL_TICKS(D_DOCR),
    .SC_DET_TICKS(D_SC), .COC_DET_TICKS(D_COC), .COC_REL_TICKS(D_COCR)
  ) i_batt_guard_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cell_ovc_i(c_ovc), .cell_ovc_rel_i(c_ovr), .cell_udc_i(c_udc),
    .cell_udc_rel_i(c_udr), .cell_wake_i(c_wake),
    .sns_doc_i(s_doc), .sns_doc_rel_i(s_docr), .sns_short_i(s_sc),
    .sns_coc_i(s_coc), .sns_coc_rel_i(s_cocr),
    .charger_i(chgr), .load_i(load),
    .chg_en_o(chg_en), .dchg_en_o(dchg_en), .sns_pullup_o(pu),
    .sns_pulldown_o(pd), .standby_o(sb)
  );

  // reference model: 0 normal, 1 overcharge, 2 short in overcharge, 3 standby,
  // 4 charger in overdischarge, 5 discharge fault, 6 charge overcurrent
  int m_mode;
  int m_cnt [9];
  int m_lim [9] = '{D_OVC, D_OVR, D_UDC, D_UDR, D_DOC, D_DOCR, D_SC, D_COC, D_COCR};

  function automatic logic [4:0] mode_out(int m);
    case (m)
      1, 6:    return 5'b01000;
      2:       return 5'b00010;
      3:       return 5'b10101;
      5:       return 5'b10010;
      default: return 5'b11000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      foreach (m_cnt[k]) m_cnt[k] = 0;
    end else begin
      bit q [9];
      bit ok [9];
      int nxt;
      q[0] = m_mode == 0 && c_ovc;
      q[1] = m_mode == 1 && !chgr && c_ovr;
      q[2] = m_mode == 0 && c_udc;
      q[3] = m_mode == 4 && c_udr;
      q[4] = m_mode == 0 && s_doc;
      q[5] = m_mode == 5 && !load && s_docr;
      q[6] = (m_mode == 0 || m_mode == 1) && s_sc;
      q[7] = m_mode == 0 && s_coc;
      q[8] = m_mode == 6 && !chgr && s_cocr;
      for (int k = 0; k < 9; k++) begin
        ok[k] = q[k] && m_cnt[k] == m_lim[k];
        if (!q[k]) m_cnt[k] = 0;
        else if (tick && m_cnt[k] < m_lim[k]) m_cnt[k]++;
      end
      nxt = m_mode;
      case (m_mode)
        0: if (ok[6] || ok[4]) nxt = 5; else if (ok[2]) nxt = 3;
           else if (ok[0]) nxt = 1; else if (ok[7]) nxt = 6;
        1: if (ok[6]) nxt = 2; else if (ok[1]) nxt = 0;
        2: if (!load && !s_sc) nxt = 1;
        3: if (chgr) nxt = 4; else if (c_wake) nxt = 0;
        4: if (ok[3]) nxt = 0; else if (!chgr) nxt = 3;
        5: if (ok[5]) nxt = 0;
        6: if (ok[8]) nxt = 0;
        default: nxt = 0;
      endcase
      m_mode = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] act, exp_v;
      act = {chg_en, dchg_en, pu, pd, sb};
      exp_v = mode_out(m_mode);
      compared++;
      if (act !== exp_v) begin
        mismatched++;
        $display("FAIL %s cycle compare: actual %b expected %b at %0t", cur_req, act, exp_v, $time);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    tick = ~tick;
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [4:0] exp_v);
    logic [4:0] act;
    act = {chg_en, dchg_en, pu, pd, sb};
    compared++;
    if (act !== exp_v) begin
      mismatched++;
      $display("FAIL %s steady check: actual %b expected %b", req, act, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(2);
    cur_req = "R1"; expect_out("R1", 5'b11000);

    cur_req = "R2";
    c_ovc = 1; hold(5); c_ovc = 0; hold(20);
    expect_out("R2", 5'b11000);

    cur_req = "R3";
    c_ovc = 1; chgr = 1; hold(30); expect_out("R3", 5'b01000);
    c_ovc = 0; c_ovr = 1; hold(30); expect_out("R3", 5'b01000);
    chgr = 0; hold(20); expect_out("R3", 5'b11000);
    c_ovr = 0;

    cur_req = "R4";
    c_ovc = 1; hold(30); expect_out("R4", 5'b01000);
    load = 1; s_sc = 1; hold(20); expect_out("R4", 5'b00010);
    s_sc = 0; hold(10); expect_out("R4", 5'b00010);
    load = 0; hold(5); expect_out("R4", 5'b01000);
    c_ovc = 0; c_ovr = 1; hold(20); expect_out("R4", 5'b11000);
    c_ovr = 0;

    cur_req = "R5";
    c_udc = 1; hold(30); expect_out("R5", 5'b10101);

    cur_req = "R6";
    chgr = 1; hold(3); expect_out("R6", 5'b11000);
    cur_req = "R8";
    s_coc = 1; hold(30); expect_out("R8", 5'b11000);
    s_coc = 0;
    cur_req = "R7";
    chgr = 0; hold(3); expect_out("R7", 5'b10101);
    chgr = 1; hold(3);
    c_udc = 0; c_udr = 1; hold(20); expect_out("R7", 5'b11000);
    chgr = 0; hold(5); expect_out("R7", 5'b11000);
    c_udr = 0;

    cur_req = "R6";
    c_udc = 1; hold(30); expect_out("R6", 5'b10101);
    c_udc = 0; c_wake = 1; hold(3); expect_out("R6", 5'b11000);
    c_wake = 0;

    cur_req = "R9";
    load = 1; s_doc = 1; hold(30); expect_out("R9", 5'b10010);
    s_doc = 0; s_docr = 1; hold(30); expect_out("R9", 5'b10010);
    load = 0; hold(20); expect_out("R9", 5'b11000);
    s_docr = 0;

    cur_req = "R10";
    load = 1; s_doc = 1; s_sc = 1; hold(8); expect_out("R10", 5'b10010);
    s_sc = 0; s_doc = 0; s_docr = 1; load = 0; hold(20); expect_out("R10", 5'b11000);
    s_docr = 0;

    cur_req = "R11";
    chgr = 1; s_coc = 1; hold(30); expect_out("R11", 5'b01000);
    s_coc = 0; s_cocr = 1; hold(30); expect_out("R11", 5'b01000);
    chgr = 0; hold(20); expect_out("R11", 5'b11000);
    s_cocr = 0;

    cur_req = "R12";
    load = 1; s_doc = 1; c_udc = 1; hold(30); expect_out("R12", 5'b10010);
    c_udc = 0; s_doc = 0; s_docr = 1; load = 0; hold(20); expect_out("R12", 5'b11000);
    s_docr = 0; hold(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule